// File: doc/BRIEF.md
# Ones-Complement Word Adder

This block adds two 18-bit ones-complement words plus a single carry-in bit. It is the arithmetic heart of a word-oriented accumulator datapath. The sign is the most significant bit (port bit 17). Any carry out of the sign position is fed back into the least significant bit (end-around carry). The block presents the result two ways: a raw sum that can be negative zero (the all-ones word), and a cleaned sum in which negative zero becomes positive zero. It also raises an overflow flag when two operands of the same sign give a result of the other sign.

The caller picks the operands to get the operation it wants. Addition takes the cleaned sum. Subtraction feeds the complement of the subtrahend as B and takes the raw sum. Increment forces A to one. A divide-step helper drives the carry-in. The caller holds any sticky overflow state itself. The arithmetic core is purely combinational. A thin registered stage captures its results for one cycle when `inValid` is high, and holds them otherwise.

Top module: `oc_add_unit`

## Requirements
- R1: One cycle after a clock edge with `inValid` high, `sumRaw` equals the ones-complement sum of `opA`, `opB` and `carryIn`. A carry out of bit 17 is added back into bit 0.
- R2: `carryIn` = 1 adds exactly one to the sum (for example 0x100 + 0 + 1 = 0x101).
- R3: `overflow` is 1 when `opA[17]` equals `opB[17]` and `sumRaw[17]` differs from them. It is 0 whenever the operand signs differ.
- R4: `sumClean` is 0 when `sumRaw` is all ones (0x3FFFF). Otherwise it equals `sumRaw`.
- R5: `sumRaw` can be negative zero. x + ~x with `carryIn` = 0 gives 0x3FFFF.
- R6: `outValid` is 1 in exactly the cycle after an edge with `inValid` high. On edges with `inValid` low, the outputs `sumRaw`, `sumClean` and `overflow` keep their values and the operand inputs are ignored.
- R7: While `rstN` is low, and after it, `sumRaw`, `sumClean`, `overflow` and `outValid` are 0 until the first accepted operation.
- R8: A repeated end-around carry is folded too. 0x3FFFF + 0x3FFFF + 1 gives 0x00001.
- R9: Subtraction a + ~b gives a − b (7 − 5 = 2, 5 − 7 = 0x3FFFD). Increment 1 + m gives m + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture the sum of the current operands |
| opA | input | 18 | Operand A, ones-complement, sign in bit 17 |
| opB | input | 18 | Operand B, ones-complement, sign in bit 17 |
| carryIn | input | 1 | Extra carry added at bit 0 |
| sumRaw | output | 18 | Registered raw sum, may be negative zero |
| sumClean | output | 18 | Registered sum with negative zero folded to zero |
| overflow | output | 1 | Registered signed overflow flag |
| outValid | output | 1 | Result registered in the previous edge |

## Verification
The bench goes after the places where a ones-complement adder is easy to get wrong.

- **Dropped end-around carry.** Subtracting a smaller value gives a result one too small (7 − 5 shows 1).
- **Double carry.** With both operands all ones and the carry-in set, an adder that folds the carry only once returns 0 instead of 1.
- **Negative zero.** x + ~x must show all ones on the raw output and zero on the cleaned output. A missing fold, or a fold placed on the wrong output, shows up at once.
- **Overflow.** The flag is checked at largest positive plus one and at the two most negative values added together. It is also checked with mixed signs, where a flag derived from the carry would wrongly fire.

// File: rtl/oc_add_pkg.sv
package oc_add_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadResult;  // capture the adder outputs this edge
  } addStrobes_t;

endpackage

// File: rtl/oc_add_core.sv
module oc_add_core #(
  parameter int WordW = 18
) (
  input  logic [WordW-1:0] a,
  input  logic [WordW-1:0] b,
  input  logic             cin,
  output logic [WordW-1:0] raw,
  output logic [WordW-1:0] clean,
  output logic             ovf
);
  localparam int SignBit = WordW - 1;

  logic [WordW:0] firstSum;
  logic [WordW:0] secondSum;

  always_comb begin
    // straight binary add including the external carry-in
    firstSum  = {1'b0, a} + {1'b0, b} + {{WordW{1'b0}}, cin};
    // end-around carry back into the low bit
    secondSum = {1'b0, firstSum[WordW-1:0]} + {{WordW{1'b0}}, firstSum[WordW]};
    // a second carry only arises when the low part wrapped to zero
    raw       = secondSum[WordW-1:0] | {{(WordW-1){1'b0}}, secondSum[WordW]};
    clean     = (&raw) ? '0 : raw;
    ovf       = (a[SignBit] == b[SignBit]) && (raw[SignBit] != a[SignBit]);
  end

endmodule

// File: rtl/oc_add_ctrl.sv
module oc_add_ctrl
  import oc_add_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output addStrobes_t strobes,
  output logic        outValid
);

  always_comb strobes.loadResult = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R6

endmodule

// File: rtl/oc_add_dp.sv
module oc_add_dp
  import oc_add_pkg::*;
#(
  parameter int WordW = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  addStrobes_t       strobes,
  input  logic [WordW-1:0]  opA,
  input  logic [WordW-1:0]  opB,
  input  logic              carryIn,
  output logic [WordW-1:0]  sumRaw,
  output logic [WordW-1:0]  sumClean,
  output logic              overflow
);
  localparam int SignBit = WordW - 1;

  logic [WordW-1:0] rawNext;
  logic [WordW-1:0] cleanNext;
  logic             ovfNext;

  oc_add_core #(.WordW(WordW)) u_core (
    .a    (opA),
    .b    (opB),
    .cin  (carryIn),
    .raw  (rawNext),
    .clean(cleanNext),
    .ovf  (ovfNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumRaw   <= '0;
      sumClean <= '0;
      overflow <= 1'b0;
    end else if (strobes.loadResult) begin
      sumRaw   <= rawNext;
      sumClean <= cleanNext;
      overflow <= ovfNext;
    end
  end

  AST_NEGZERO_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (&sumRaw) |-> (sumClean == '0));  // R4
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !(&sumRaw) |-> (sumClean == sumRaw));  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadResult && (opA[SignBit] != opB[SignBit])) |=> !overflow);  // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadResult |=> ($stable(sumRaw) && $stable(overflow)));  // R6

endmodule

// File: rtl/oc_add_unit.sv
module oc_add_unit
  import oc_add_pkg::*;
#(
  parameter int WordW = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WordW-1:0] opA,
  input  logic [WordW-1:0] opB,
  input  logic             carryIn,
  output logic [WordW-1:0] sumRaw,
  output logic [WordW-1:0] sumClean,
  output logic             overflow,
  output logic             outValid
);

  addStrobes_t strobes;

  oc_add_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  oc_add_dp #(.WordW(WordW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .sumRaw  (sumRaw),
    .sumClean(sumClean),
    .overflow(overflow)
  );

endmodule

// File: tb/oc_add_unit_bench.sv
module oc_add_unit_bench;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumRaw, sumClean;
  logic         overflow, outValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;  // 250 MHz

  oc_add_unit u_oc_add_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .carryIn(carryIn), .sumRaw(sumRaw), .sumClean(sumClean),
    .overflow(overflow), .outValid(outValid)
  );

  // reference: add as integers, fold every wrap back in as +1
  function automatic logic [W-1:0] refSum(input logic [W-1:0] a, b, input logic c);
    longint v = longint'(a) + longint'(b) + longint'(c);
    while (v >= (longint'(1) << W)) v = v - (longint'(1) << W) + 1;
    return v[W-1:0];
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one accepted operation; samples at the negedge after the capturing edge
  task automatic apply(input logic [W-1:0] a, b, input logic c);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkFull(input string tag, input logic [W-1:0] a, b, input logic c);
    logic [W-1:0] r;
    logic ov;
    apply(a, b, c);
    r  = refSum(a, b, c);
    ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    check({tag, " raw R1"}, sumRaw, r);
    check({tag, " clean R4"}, sumClean, (r == ONES) ? '0 : r);
    check({tag, " ovf R3"}, overflow, ov);
    check({tag, " valid R6"}, outValid, 1);
  endtask

  task automatic testReset();
    check("reset raw R7", sumRaw, 0);
    check("reset clean R7", sumClean, 0);
    check("reset ovf R7", overflow, 0);
    check("reset valid R7", outValid, 0);
  endtask

  task automatic testBasic();
    apply(18'd5, 18'd7, 1'b0);
    check("5+7 R1", sumRaw, 12);
    checkFull("mix1", 18'o123456, 18'o054321, 1'b0);
    checkFull("mix2", 18'o700001, 18'o000777, 1'b0);
    checkFull("mix3", 18'o612345, 18'o654321, 1'b0);
  endtask

  task automatic testCarryIn();
    apply(18'h100, 18'h0, 1'b1);
    check("cin +1 R2", sumRaw, 18'h101);
    checkFull("cin mix R2", 18'o400000, 18'o377777, 1'b1);
  endtask

  task automatic testSubInc();
    apply(18'd7, ~18'd5, 1'b0);
    check("7-5 R9", sumRaw, 2);
    apply(18'd5, ~18'd7, 1'b0);
    check("5-7 R9", sumRaw, 18'h3FFFD);
    apply(18'd1, 18'd41, 1'b0);
    check("inc R9", sumRaw, 42);
  endtask

  task automatic testNegZero();
    apply(18'o123456, ~18'o123456, 1'b0);
    check("x+~x raw R5", sumRaw, ONES);
    check("x+~x clean R4", sumClean, 0);
    check("x+~x ovf R3", overflow, 0);
  endtask

  task automatic testOverflow();
    apply(18'o377777, 18'd1, 1'b0);
    check("maxpos+1 ovf R3", overflow, 1);
    check("maxpos+1 raw R1", sumRaw, 18'o400000);
    apply(18'o400000, 18'o400000, 1'b0);
    check("minneg*2 ovf R3", overflow, 1);
    check("minneg*2 raw R1", sumRaw, 1);
    apply(18'o377777, 18'o600000, 1'b0);
    check("mixed sign ovf R3", overflow, 0);
  endtask

  task automatic testDoubleCarry();
    apply(ONES, ONES, 1'b1);
    check("double carry R8", sumRaw, 1);
    check("double carry clean R8", sumClean, 1);
  endtask

  task automatic testHold();
    logic [W-1:0] keepRaw;
    apply(18'd100, 18'd23, 1'b0);
    keepRaw = sumRaw;
    @(negedge clk);
    opA = 18'o377777; opB = 18'd1; carryIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("hold raw R6", sumRaw, keepRaw);
    check("hold ovf R6", overflow, 0);
    check("hold valid R6", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testCarryIn();
    testSubInc();
    testNegZero();
    testOverflow();
    testDoubleCarry();
    testHold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R6: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule